// File: doc/BRIEF.md
# Multi-Channel DMA Channel Control Register Bank

This block holds the programming state of every channel of a multi-channel DMA controller and presents it to the data-movement engine. Software reaches it through a plain 32-bit register bus with a combinational read path and single-cycle writes. Each channel owns a 64-byte window. The window holds a source address, a destination address, a byte count, a two-dimensional count, two step values, a next-descriptor pointer and a control word. The block decodes the control word into per-channel enable, software-request, FIFO-mode, burst and interrupt-enable outputs.

The engine itself is outside the block. The block starts a channel when software writes the control word with enable set. It pauses the channel when enable is cleared and resumes it when enable is set again, and the channel keeps its state throughout. A force-close write aborts the channel. The engine reports the end of a transfer through a per-channel done input. A global status word shows one busy bit per channel. A global arbitration word resets to zero, which means all channels have equal priority.

Top module: `dmacr_top`

## Requirements
- R1: After reset every channel register reads zero, no channel is busy, the status word at 0x820 reads zero and the arbitration word at 0x828 reads zero.
- R2: Channel n's window starts at n*0x40. Within a window the registers sit at these offsets, each readable and writable: source 0x00, destination 0x04, byte count 0x08, 2D count 0x0C, source step 0x10, destination step 0x14, next pointer 0x1C. Offset 0x18 reads zero.
- R3: The control word sits at offset 0x20. Its bit 0 is enable, bit 1 is software request, bit 2 is source FIFO mode, bit 3 is destination FIFO mode, bits 5:4 are the interrupt enables, bits 8:6 are the source width code and bits 15:13 are the destination width code. Each of these fields drives its own output. Bits 12:9 hold the burst length minus one, and the burst output presents the length in beats, from 1 to 16.
- R4: Writing the control word with bit 0 set to an idle channel makes the channel busy and running from the next cycle. It also gives a start pulse that lasts exactly one cycle.
- R5: Writing the control word with bit 0 clear and bit 31 clear to a busy channel pauses it: the channel stays busy, the run output goes low and the other registers keep their values.
- R6: Writing the control word with bit 0 set to a paused channel resumes it: the run output returns high and no start pulse is produced.
- R7: Writing the control word with bit 31 set aborts the channel. From the next cycle the channel is no longer busy, enable reads as zero and bit 31 reads as zero, and the abort output pulses for one cycle.
- R8: A done pulse from the engine on a busy channel clears that channel's busy bit and its stored enable bit.
- R9: Bit n of the status word at 0x820 is set while channel n is busy. Writes to 0x820 have no effect.
- R10: The arbitration word at 0x828 is readable and writable, and its value drives the arbitration output.
- R11: A write to one channel's window leaves every other channel's registers and outputs unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 12 | Register byte address |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| eng_done | input | NCH | Per-channel transfer-finished pulse from the engine |
| ch_busy | output | NCH | Channel active (started, not finished or aborted) |
| ch_run | output | NCH | Channel busy and not paused |
| ch_start | output | NCH | One-cycle pulse when a channel starts |
| ch_abort | output | NCH | One-cycle pulse when a channel is force-closed |
| ch_soft_req | output | NCH | Software request bit |
| ch_src_fifo | output | NCH | Source FIFO (fixed address) mode |
| ch_dst_fifo | output | NCH | Destination FIFO (fixed address) mode |
| ch_irq_en | output | 2*NCH | Interrupt enables, two bits per channel |
| ch_src_width | output | 3*NCH | Source width code (0=8b, 1=16b, 2=32b, 3=64b) |
| ch_dst_width | output | 3*NCH | Destination width code |
| ch_burst_beats | output | 5*NCH | Burst length in beats (1..16) |
| arb_prio | output | 32 | Arbitration word |

## Verification
Two different control words are written to an idle channel, one with the largest burst and wide widths and one with the smallest burst and narrow widths. Comparing the two sets of outputs shows whether every field is decoded from the right bits and whether the length-minus-one offset is applied. The lifecycle of a channel is run as start, pause, resume and then completion by engine done. A separate channel is started and then force-closed. These runs separate pause from abort by busy, run and pulse outputs, and resume from a fresh start by the absence of a start pulse. Writes to neighbouring windows and to the read-only status word confirm that writes reach only the register they address.

// File: rtl/dmacr_pkg.sv
package dmacr_pkg;

    localparam int OFF_W = 6;

    localparam logic [OFF_W-1:0] OFF_SRC   = 6'h00;
    localparam logic [OFF_W-1:0] OFF_DST   = 6'h04;
    localparam logic [OFF_W-1:0] OFF_XCNT  = 6'h08;
    localparam logic [OFF_W-1:0] OFF_ZYCNT = 6'h0C;
    localparam logic [OFF_W-1:0] OFF_SSTEP = 6'h10;
    localparam logic [OFF_W-1:0] OFF_DSTEP = 6'h14;
    localparam logic [OFF_W-1:0] OFF_NEXT  = 6'h1C;
    localparam logic [OFF_W-1:0] OFF_CTRL  = 6'h20;

    localparam logic [11:0] ADDR_STATUS = 12'h820;
    localparam logic [11:0] ADDR_ARB    = 12'h828;

    localparam int FC_BIT  = 31;
    localparam int BEATS_W = 5;

    // Stored part of the control word; LSB is the enable bit
    typedef struct packed {
        logic [2:0] dst_wid;
        logic [3:0] len_m1;
        logic [2:0] src_wid;
        logic [1:0] irq_en;
        logic       dst_fifo;
        logic       src_fifo;
        logic       soft_req;
        logic       en;
    } ctrl_t;

    localparam int CTRL_W = $bits(ctrl_t);

    function automatic logic [BEATS_W-1:0] to_beats(input logic [3:0] m1);
        return BEATS_W'(m1) + BEATS_W'(1);
    endfunction

endpackage

// File: rtl/dmacr_chan.sv
module dmacr_chan
    import dmacr_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_sel,
    input  logic [OFF_W-1:0] off,
    input  logic [DW-1:0]    wdata,
    input  logic             eng_done,
    output logic [DW-1:0]    rdata,
    output ctrl_t            ctrl,
    output logic             busy,
    output logic             start,
    output logic             abort
);

    logic [DW-1:0] src_q, dst_q, xcnt_q, zycnt_q, sstep_q, dstep_q, next_q;
    logic          ctrl_wr, fc_wr;
    ctrl_t         wctrl;

    assign ctrl_wr = wr_sel && (off == OFF_CTRL);
    assign fc_wr   = ctrl_wr && wdata[FC_BIT];

    always_comb begin
        wctrl = ctrl_t'(wdata[CTRL_W-1:0]);
        if (wdata[FC_BIT]) wctrl.en = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            src_q <= '0; dst_q <= '0; xcnt_q <= '0; zycnt_q <= '0;
            sstep_q <= '0; dstep_q <= '0; next_q <= '0;
            ctrl <= '0; busy <= 1'b0; start <= 1'b0; abort <= 1'b0;
        end else begin
            start <= 1'b0;
            abort <= 1'b0;
            if (wr_sel) begin
                case (off)
                    OFF_SRC:   src_q   <= wdata;
                    OFF_DST:   dst_q   <= wdata;
                    OFF_XCNT:  xcnt_q  <= wdata;
                    OFF_ZYCNT: zycnt_q <= wdata;
                    OFF_SSTEP: sstep_q <= wdata;
                    OFF_DSTEP: dstep_q <= wdata;
                    OFF_NEXT:  next_q  <= wdata;
                    default: ;
                endcase
            end
            if (ctrl_wr) begin
                ctrl <= wctrl;
                if (wdata[FC_BIT]) begin
                    busy  <= 1'b0;
                    abort <= 1'b1;
                end else if (wctrl.en && !busy) begin
                    busy  <= 1'b1;
                    start <= 1'b1;
                end
            end else if (eng_done && busy) begin
                busy    <= 1'b0;
                ctrl.en <= 1'b0;
            end
        end
    end

    always_comb begin
        case (off)
            OFF_SRC:   rdata = src_q;
            OFF_DST:   rdata = dst_q;
            OFF_XCNT:  rdata = xcnt_q;
            OFF_ZYCNT: rdata = zycnt_q;
            OFF_SSTEP: rdata = sstep_q;
            OFF_DSTEP: rdata = dstep_q;
            OFF_NEXT:  rdata = next_q;
            OFF_CTRL:  rdata = DW'(ctrl);
            default:   rdata = '0;
        endcase
    end

    AST_START_SETS_BUSY: assert property (@(posedge clk) disable iff (rst)
        start |-> busy && ctrl.en);                                        // R4
    AST_ABORT_IDLE: assert property (@(posedge clk) disable iff (rst)
        abort |-> !busy && !ctrl.en);                                      // R7
    AST_BUSY_FALL_CAUSE: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> $past(eng_done) || $past(fc_wr));                  // R8
    AST_PAUSE_KEEPS_SRC: assert property (@(posedge clk) disable iff (rst)
        (busy && !wr_sel) |=> $stable(src_q));                             // R5

endmodule

// File: rtl/dmacr_glob.sv
module dmacr_glob
    import dmacr_pkg::*;
#(
    parameter int NCH = 4,
    parameter int DW  = 32
) (
    input  logic           clk,
    input  logic           rst,
    input  logic [11:0]    addr,
    input  logic           wr,
    input  logic [DW-1:0]  wdata,
    input  logic [NCH-1:0] busy,
    output logic [DW-1:0]  rdata,
    output logic [DW-1:0]  arb
);

    logic arb_wr;
    assign arb_wr = wr && (addr == ADDR_ARB);

    always_ff @(posedge clk) begin
        if (rst)         arb <= '0;
        else if (arb_wr) arb <= wdata;
    end

    always_comb begin
        if (addr == ADDR_STATUS)   rdata = DW'(busy);
        else if (addr == ADDR_ARB) rdata = arb;
        else                       rdata = '0;
    end

    AST_ARB_HOLD: assert property (@(posedge clk) disable iff (rst)
        !arb_wr |=> $stable(arb));                                         // R10

endmodule

// File: rtl/dmacr_top.sv
module dmacr_top
    import dmacr_pkg::*;
#(
    parameter int NCH = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [11:0]        bus_addr,
    input  logic               bus_wr,
    input  logic [31:0]        bus_wdata,
    output logic [31:0]        bus_rdata,
    input  logic [NCH-1:0]     eng_done,
    output logic [NCH-1:0]     ch_busy,
    output logic [NCH-1:0]     ch_run,
    output logic [NCH-1:0]     ch_start,
    output logic [NCH-1:0]     ch_abort,
    output logic [NCH-1:0]     ch_soft_req,
    output logic [NCH-1:0]     ch_src_fifo,
    output logic [NCH-1:0]     ch_dst_fifo,
    output logic [2*NCH-1:0]   ch_irq_en,
    output logic [3*NCH-1:0]   ch_src_width,
    output logic [3*NCH-1:0]   ch_dst_width,
    output logic [5*NCH-1:0]   ch_burst_beats,
    output logic [31:0]        arb_prio
);

    localparam int DW = 32;

    logic          is_glob;
    logic [4:0]    win;
    logic [DW-1:0] ch_rd [NCH];
    logic [DW-1:0] glob_rd;
    ctrl_t         ctrl [NCH];

    assign is_glob = bus_addr[11];
    assign win     = bus_addr[10:6];

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        logic sel;
        assign sel = bus_wr && !is_glob && (win == 5'(i));

        dmacr_chan #(.DW(DW)) u_chan (
            .clk      (clk),
            .rst      (rst),
            .wr_sel   (sel),
            .off      (bus_addr[OFF_W-1:0]),
            .wdata    (bus_wdata),
            .eng_done (eng_done[i]),
            .rdata    (ch_rd[i]),
            .ctrl     (ctrl[i]),
            .busy     (ch_busy[i]),
            .start    (ch_start[i]),
            .abort    (ch_abort[i])
        );

        assign ch_run[i]                  = ch_busy[i] && ctrl[i].en;
        assign ch_soft_req[i]             = ctrl[i].soft_req;
        assign ch_src_fifo[i]             = ctrl[i].src_fifo;
        assign ch_dst_fifo[i]             = ctrl[i].dst_fifo;
        assign ch_irq_en[2*i +: 2]        = ctrl[i].irq_en;
        assign ch_src_width[3*i +: 3]     = ctrl[i].src_wid;
        assign ch_dst_width[3*i +: 3]     = ctrl[i].dst_wid;
        assign ch_burst_beats[5*i +: 5]   = to_beats(ctrl[i].len_m1);
    end

    dmacr_glob #(.NCH(NCH), .DW(DW)) u_glob (
        .clk   (clk),
        .rst   (rst),
        .addr  (bus_addr),
        .wr    (bus_wr),
        .wdata (bus_wdata),
        .busy  (ch_busy),
        .rdata (glob_rd),
        .arb   (arb_prio)
    );

    always_comb begin
        bus_rdata = '0;
        if (is_glob) bus_rdata = glob_rd;
        else begin
            for (int i = 0; i < NCH; i++)
                if (win == 5'(i)) bus_rdata = ch_rd[i];
        end
    end

endmodule

// File: tb/dmacr_top_bench.sv
module dmacr_top_bench;

    localparam int NCH = 4;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [11:0]       bus_addr = '0;
    logic              bus_wr = 1'b0;
    logic [31:0]       bus_wdata = '0;
    logic [31:0]       bus_rdata;
    logic [NCH-1:0]    eng_done = '0;
    logic [NCH-1:0]    ch_busy, ch_run, ch_start, ch_abort;
    logic [NCH-1:0]    ch_soft_req, ch_src_fifo, ch_dst_fifo;
    logic [2*NCH-1:0]  ch_irq_en;
    logic [3*NCH-1:0]  ch_src_width, ch_dst_width;
    logic [5*NCH-1:0]  ch_burst_beats;
    logic [31:0]       arb_prio;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    dmacr_top #(.NCH(NCH)) u_dmacr_top (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .eng_done(eng_done),
        .ch_busy(ch_busy), .ch_run(ch_run), .ch_start(ch_start),
        .ch_abort(ch_abort), .ch_soft_req(ch_soft_req),
        .ch_src_fifo(ch_src_fifo), .ch_dst_fifo(ch_dst_fifo),
        .ch_irq_en(ch_irq_en), .ch_src_width(ch_src_width),
        .ch_dst_width(ch_dst_width), .ch_burst_beats(ch_burst_beats),
        .arb_prio(arb_prio)
    );

    task automatic check(input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    // drive at a falling edge; return at the next falling edge
    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        bus_addr = a;
        #0.5;
        d = bus_rdata;
    endtask

    task automatic t_reset;
        logic [31:0] v;
        rd(12'h020, v); check("R1 ch0 ctrl", v, 0);
        rd(12'h0C0, v); check("R1 ch3 src", v, 0);
        rd(12'h820, v); check("R1 status", v, 0);
        rd(12'h828, v); check("R1 arb", v, 0);
        check("R1 busy", 32'(ch_busy), 0);
    endtask

    task automatic t_regmap;
        logic [31:0] v;
        logic [5:0] offs [7] = '{6'h00, 6'h04, 6'h08, 6'h0C, 6'h10, 6'h14, 6'h1C};
        foreach (offs[k]) wr(12'h040 + 12'(offs[k]), 32'h1100_0000 + 32'(k) * 32'h0101);
        foreach (offs[k]) begin
            rd(12'h040 + 12'(offs[k]), v);
            check("R2 readback", v, 32'h1100_0000 + 32'(k) * 32'h0101);
        end
        rd(12'h058, v); check("R2 hole 0x18", v, 0);
        rd(12'h000, v); check("R11 ch0 src untouched", v, 0);
        rd(12'h084, v); check("R11 ch2 dst untouched", v, 0);
    endtask

    task automatic t_decode;
        wr(12'h0A0, 32'h0000_7EB6);
        check("R3 beats 16", 32'(ch_burst_beats[10 +: 5]), 16);
        check("R3 src width", 32'(ch_src_width[6 +: 3]), 2);
        check("R3 dst width", 32'(ch_dst_width[6 +: 3]), 3);
        check("R3 irq en", 32'(ch_irq_en[4 +: 2]), 3);
        check("R3 soft req", 32'(ch_soft_req[2]), 1);
        check("R3 src fifo", 32'(ch_src_fifo[2]), 1);
        check("R3 dst fifo", 32'(ch_dst_fifo[2]), 0);
        check("R3 no start without enable", 32'(ch_busy[2]), 0);
        wr(12'h0A0, 32'h0000_2008);
        check("R3 beats 1", 32'(ch_burst_beats[10 +: 5]), 1);
        check("R3 src width 0", 32'(ch_src_width[6 +: 3]), 0);
        check("R3 dst width 1", 32'(ch_dst_width[6 +: 3]), 1);
        check("R3 dst fifo set", 32'(ch_dst_fifo[2]), 1);
        check("R3 src fifo clr", 32'(ch_src_fifo[2]), 0);
        check("R11 ch1 untouched", 32'(ch_burst_beats[5 +: 5]), 1);
    endtask

    task automatic t_lifecycle;
        logic [31:0] v;
        wr(12'h000, 32'hA000_0000);
        wr(12'h020, 32'h0000_0001);
        check("R4 start pulse", 32'(ch_start[0]), 1);
        check("R4 busy", 32'(ch_busy[0]), 1);
        check("R4 run", 32'(ch_run[0]), 1);
        @(negedge clk);
        check("R4 start one cycle", 32'(ch_start[0]), 0);
        rd(12'h820, v); check("R9 status", v, 32'h1);
        wr(12'h020, 32'h0000_0000);
        check("R5 pause keeps busy", 32'(ch_busy[0]), 1);
        check("R5 pause stops run", 32'(ch_run[0]), 0);
        check("R5 no abort", 32'(ch_abort[0]), 0);
        rd(12'h000, v); check("R5 src kept", v, 32'hA000_0000);
        wr(12'h020, 32'h0000_0001);
        check("R6 resume run", 32'(ch_run[0]), 1);
        check("R6 no start pulse", 32'(ch_start[0]), 0);
        @(negedge clk);
        eng_done[0] = 1'b1;
        @(negedge clk);
        eng_done[0] = 1'b0;
        check("R8 done clears busy", 32'(ch_busy[0]), 0);
        rd(12'h020, v); check("R8 enable cleared", v & 32'h1, 0);
    endtask

    task automatic t_abort;
        logic [31:0] v;
        wr(12'h0E0, 32'h0000_0031);
        check("R7 pre busy", 32'(ch_busy[3]), 1);
        wr(12'h0E0, 32'h8000_0030);
        check("R7 busy cleared", 32'(ch_busy[3]), 0);
        check("R7 abort pulse", 32'(ch_abort[3]), 1);
        rd(12'h0E0, v); check("R7 readback no en no fc", v, 32'h30);
        @(negedge clk);
        check("R7 abort one cycle", 32'(ch_abort[3]), 0);
    endtask

    task automatic t_global;
        logic [31:0] v;
        wr(12'h060, 32'h0000_0001);
        wr(12'h820, 32'h0000_000F);
        rd(12'h820, v); check("R9 status ignores write", v, 32'h2);
        wr(12'h828, 32'h0000_0005);
        rd(12'h828, v); check("R10 arb readback", v, 32'h5);
        check("R10 arb output", arb_prio, 32'h5);
    endtask

    initial begin
        fork
            begin
                repeat (3) @(negedge clk);
                rst = 1'b0;
                t_reset();
                t_regmap();
                t_decode();
                t_lifecycle();
                t_abort();
                t_global();
            end
            begin
                repeat (5000) @(posedge clk);
                checks++;
                errors++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        disable fork;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule